// File: doc/BRIEF.md
# Video memory bus address decoder

This block sits on the 14-bit address bus of a video processor. It splits every access among three storage regions and performs the read or write in that region. The lowest 8 KiB of the space is pattern storage. This is a small internal array that either behaves as RAM or returns fixed ROM bytes, chosen by a select pin. The middle of the space is a 2 KiB nametable RAM. Its four logical screens fold onto two physical pages according to a mirroring selector. The top 256 bytes reach a 32-byte palette RAM, in which four backdrop entries share storage with their lower twins.

Read data is combinational from the current address. A write lands on the rising clock edge while the write strobe is high. A separate latch keeps the last value seen on the bus: the byte returned by a read, or the byte supplied by a write. Both strobes are plain control pins. The block accepts an access in every cycle and never applies back-pressure, so no valid/ready handshake is needed. Reset clears only the bus latch. The memory contents survive reset.

Top module: `vbus_decoder`

## Requirements
- R1: Address bit 13 clear selects pattern storage. Addresses 0x3F00-0x3FFF select the palette. All other addresses (0x2000-0x3EFF) select the nametable RAM.
- R2: Mirroring code 0 (horizontal) forms the nametable offset as {addr[11], addr[9:0]}. This folds 0x2000/0x2400 onto page 0 and 0x2800/0x2C00 onto page 1.
- R3: Mirroring code 1 (vertical) forms the offset as {addr[10], addr[9:0]}. This folds 0x2000/0x2800 onto page 0 and 0x2400/0x2C00 onto page 1.
- R4: Code 2 maps all four screens onto page 0 (offsets 0x000-0x3FF). Code 3 maps all four onto page 1 (offsets 0x400-0x7FF).
- R5: Code 4 (four-screen) returns 0x00 for every nametable read and discards every nametable write.
- R6: Codes 5, 6 and 7 behave exactly like code 0.
- R7: The palette index is addr[4:0]. Indices 0x10, 0x14, 0x18 and 0x1C are reduced by 16, so each shares a cell with 0x00, 0x04, 0x08 or 0x0C. All other indices are distinct.
- R8: Pattern accesses use index addr[5:0], so the region aliases every 64 bytes. With pat_rom_sel low the storage is RAM: writes are kept and reads return them. With pat_rom_sel high, reads return the ROM byte ((idx*0x1D) mod 256) XOR 0x5A and writes change nothing.
- R9: bus_latch takes the write data on a write edge. Otherwise, on a read edge, it takes the read data. It holds in all other cycles and is 0x00 after reset.
- R10: Writes take effect at the clock edge and are visible to a read in the next cycle. Nametable and palette contents are not altered by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the bus latch |
| addr | input | 14 | Bus address |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Read strobe (updates the latch) |
| wr_en | input | 1 | Write strobe |
| mirror_sel | input | 3 | Nametable mirroring code (0 horz, 1 vert, 2 page0, 3 page1, 4 four-screen) |
| pat_rom_sel | input | 1 | 1: pattern storage is ROM, 0: RAM |
| rdata | output | 8 | Combinational read data |
| bus_latch | output | 8 | Last bus value |

## Verification
The assertions check four rules on every cycle. The latch follows write data on a write and read data on a read. A four-screen nametable read always yields zero. The palette index handed to storage is never one of the four aliased backdrop slots. A pattern write never reaches storage in ROM mode. Only the bench scenarios can show where each mirroring mode actually folds the screens and that the palette pairs truly share data. They also show that a write dropped in four-screen or ROM mode leaves the old contents intact, and that memory survives reset. The bench does this by writing through one alias and reading through another.

// File: rtl/vbus_pkg.sv
package vbus_pkg;
  typedef enum logic [2:0] {
    MIR_HORZ   = 3'd0,
    MIR_VERT   = 3'd1,
    MIR_PAGE0  = 3'd2,
    MIR_PAGE1  = 3'd3,
    MIR_FOUR   = 3'd4
  } mirror_e;

  typedef enum logic [1:0] {
    RGN_PAT = 2'd0,
    RGN_NT  = 2'd1,
    RGN_PAL = 2'd2
  } region_e;
endpackage

// File: rtl/vbus_addr_map.sv
module vbus_addr_map
  import vbus_pkg::*;
#(
  parameter int AW     = 14,
  parameter int NT_AW  = 11,
  parameter int PAL_AW = 5,
  parameter int PAT_AW = 6
) (
  input  logic [AW-1:0]     addr,
  input  logic [2:0]        mirror_sel,
  output region_e           region,
  output logic              nt_blocked,
  output logic [NT_AW-1:0]  nt_off,
  output logic [PAL_AW-1:0] pal_idx,
  output logic [PAT_AW-1:0] pat_idx
);
  localparam int PAGE_W = NT_AW - 1;

  logic              page;
  logic [PAL_AW-1:0] pal_raw;
  logic              unused_hi;

  assign unused_hi = ^addr[PAGE_W+1 +: 1];

  // R1 region select
  always_comb begin
    if (!addr[AW-1])
      region = RGN_PAT;
    else if (addr[AW-2:8] == {(AW-9){1'b1}})
      region = RGN_PAL;
    else
      region = RGN_NT;
  end

  // R2..R6 physical page choice
  always_comb begin
    nt_blocked = 1'b0;
    case (mirror_sel)
      MIR_VERT:  page = addr[PAGE_W];
      MIR_PAGE0: page = 1'b0;
      MIR_PAGE1: page = 1'b1;
      MIR_FOUR: begin
        page       = 1'b0;
        nt_blocked = 1'b1;
      end
      default:   page = addr[PAGE_W+1];
    endcase
  end

  assign nt_off = {page, addr[PAGE_W-1:0]};

  // R7 backdrop aliasing
  assign pal_raw = addr[PAL_AW-1:0];
  always_comb begin
    pal_idx = pal_raw;
    if (pal_raw[PAL_AW-1] && pal_raw[1:0] == 2'b00)
      pal_idx[PAL_AW-1] = 1'b0;
  end

  assign pat_idx = addr[PAT_AW-1:0];
endmodule

// File: rtl/vbus_byte_ram.sv
module vbus_byte_ram #(
  parameter int AW = 5,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // R10 no reset of contents
  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end

  assign rdata = mem[idx];
endmodule

// File: rtl/vbus_pattern_store.sv
module vbus_pattern_store #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rom_sel,
  input  logic          we,
  input  logic [AW-1:0] idx,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [7:0] ram_q;
  logic [7:0] rom_q;
  logic       ram_we;
  logic [15:0] prod;

  assign ram_we = we && !rom_sel;

  vbus_byte_ram #(.AW(AW), .DW(8)) u_ram (
    .clk  (clk),
    .we   (ram_we),
    .idx  (idx),
    .wdata(wdata),
    .rdata(ram_q)
  );

  // R8 ROM bytes computed from the index
  assign prod  = 16'(idx) * 16'h001D;
  assign rom_q = prod[7:0] ^ 8'h5A;
  assign rdata = rom_sel ? rom_q : ram_q;

  // R8
  rom_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rom_sel |-> !ram_we);
endmodule

// File: rtl/vbus_decoder.sv
module vbus_decoder
  import vbus_pkg::*;
#(
  parameter int AW     = 14,
  parameter int DW     = 8,
  parameter int NT_AW  = 11,
  parameter int PAL_AW = 5,
  parameter int PAT_AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [13:0]   addr,
  input  logic [7:0]    wdata,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [2:0]    mirror_sel,
  input  logic          pat_rom_sel,
  output logic [7:0]    rdata,
  output logic [7:0]    bus_latch
);
  region_e           region;
  logic              nt_blocked;
  logic [NT_AW-1:0]  nt_off;
  logic [PAL_AW-1:0] pal_idx;
  logic [PAT_AW-1:0] pat_idx;
  logic [DW-1:0]     nt_q, pal_q, pat_q;
  logic              nt_we, pal_we, pat_we;

  vbus_addr_map #(.AW(AW), .NT_AW(NT_AW), .PAL_AW(PAL_AW), .PAT_AW(PAT_AW)) u_map (
    .addr      (addr),
    .mirror_sel(mirror_sel),
    .region    (region),
    .nt_blocked(nt_blocked),
    .nt_off    (nt_off),
    .pal_idx   (pal_idx),
    .pat_idx   (pat_idx)
  );

  assign nt_we  = wr_en && region == RGN_NT && !nt_blocked;
  assign pal_we = wr_en && region == RGN_PAL;
  assign pat_we = wr_en && region == RGN_PAT;

  vbus_byte_ram #(.AW(NT_AW), .DW(DW)) u_nt (
    .clk(clk), .we(nt_we), .idx(nt_off), .wdata(wdata), .rdata(nt_q)
  );

  vbus_byte_ram #(.AW(PAL_AW), .DW(DW)) u_pal (
    .clk(clk), .we(pal_we), .idx(pal_idx), .wdata(wdata), .rdata(pal_q)
  );

  // R7
  always_comb begin
    if (rst_n) begin
      pal_alias_chk: assert (!(pal_idx[PAL_AW-1] && pal_idx[1:0] == 2'b00));
    end
  end

  vbus_pattern_store #(.AW(PAT_AW)) u_pat (
    .clk(clk), .rst_n(rst_n), .rom_sel(pat_rom_sel), .we(pat_we),
    .idx(pat_idx), .wdata(wdata), .rdata(pat_q)
  );

  always_comb begin
    case (region)
      RGN_PAT: rdata = pat_q;
      RGN_PAL: rdata = pal_q;
      default: rdata = nt_blocked ? '0 : nt_q;
    endcase
  end

  // R9 last bus value
  always_ff @(posedge clk) begin
    if (!rst_n)     bus_latch <= '0;
    else if (wr_en) bus_latch <= wdata;
    else if (rd_en) bus_latch <= rdata;
  end

  // R5
  four_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mirror_sel == 3'd4 && addr >= 14'h2000 && addr < 14'h3F00) |-> rdata == 8'h00);

  // R9
  latch_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> bus_latch == $past(wdata));

  // R9
  latch_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en) |=> bus_latch == $past(rdata));
endmodule

// File: tb/vbus_decoder_tb.sv
module vbus_decoder_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [13:0] addr = 0;
  logic [7:0]  wdata = 0;
  logic        rd_en = 0, wr_en = 0;
  logic [2:0]  mirror_sel = 0;
  logic        pat_rom_sel = 0;
  logic [7:0]  rdata, bus_latch;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  vbus_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .rd_en(rd_en),
    .wr_en(wr_en), .mirror_sel(mirror_sel), .pat_rom_sel(pat_rom_sel),
    .rdata(rdata), .bus_latch(bus_latch)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [13:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic do_read(input logic [13:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1;
    #2 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  function automatic logic model_page(input logic [2:0] m, input logic [13:0] a);
    case (m)
      3'd1: return a[10];
      3'd2: return 1'b0;
      3'd3: return 1'b1;
      default: return a[11];
    endcase
  endfunction

  logic [13:0] pts [7] = '{14'h2000, 14'h2005, 14'h23FF, 14'h2400, 14'h2800, 14'h2C00, 14'h2FFF};

  function automatic int lo_key(input logic [13:0] a);
    return (a[9:0] == 10'h000) ? 0 : (a[9:0] == 10'h005) ? 1 : 2;
  endfunction

  // seed both pages through the single-page modes (R4)
  task automatic t_seed;
    logic [13:0] offs [3] = '{14'h2000, 14'h2005, 14'h23FF};
    for (int k = 0; k < 3; k++) begin
      mirror_sel = 3'd2; do_write(offs[k], 8'h10 + 8'(k));
      mirror_sel = 3'd3; do_write(offs[k], 8'h80 + 8'(k));
    end
  endtask

  task automatic t_mode(input logic [2:0] m, input string tag);
    logic [7:0] d;
    mirror_sel = m;
    for (int i = 0; i < 7; i++) begin
      do_read(pts[i], d);
      if (m == 3'd4) chk(tag, d, 8'h00);
      else chk(tag, d, (model_page(m, pts[i]) ? 8'h80 : 8'h10) + 8'(lo_key(pts[i])));
    end
  endtask

  task automatic t_four_drop;
    logic [7:0] d;
    mirror_sel = 3'd4; do_write(14'h2005, 8'hEE);
    mirror_sel = 3'd2; do_read(14'h2005, d); chk("R5 drop p0", d, 8'h11);
    mirror_sel = 3'd3; do_read(14'h2005, d); chk("R5 drop p1", d, 8'h81);
  endtask

  task automatic t_palette;
    logic [7:0] d;
    for (int p = 0; p < 4; p++) begin
      do_write(14'h3F10 + 14'(4*p), 8'hA0 + 8'(p));
      do_read(14'h3F00 + 14'(4*p), d); chk("R7 hi->lo alias", d, 8'hA0 + 8'(p));
      do_write(14'h3F00 + 14'(4*p), 8'hC0 + 8'(p));
      do_read(14'h3F10 + 14'(4*p), d); chk("R7 lo->hi alias", d, 8'hC0 + 8'(p));
    end
    do_write(14'h3F01, 8'h31); do_write(14'h3F11, 8'h32);
    do_read(14'h3F01, d); chk("R7 distinct 01", d, 8'h31);
    do_read(14'h3F31, d); chk("R7 mirror 0x3F31 R1", d, 8'h32);
  endtask

  task automatic t_pattern;
    logic [7:0] d;
    logic [15:0] prod;
    pat_rom_sel = 0;
    do_write(14'h0003, 8'h77);
    do_read(14'h0003, d);  chk("R8 ram readback", d, 8'h77);
    do_read(14'h1FC3, d);  chk("R8 ram alias R1", d, 8'h77);
    pat_rom_sel = 1;
    do_write(14'h0003, 8'h99);
    prod = 16'd3 * 16'h1D;
    do_read(14'h0003, d);  chk("R8 rom byte", d, prod[7:0] ^ 8'h5A);
    prod = 16'd45 * 16'h1D;
    do_read(14'h002D, d);  chk("R8 rom byte 2D", d, prod[7:0] ^ 8'h5A);
    pat_rom_sel = 0;
    do_read(14'h0003, d);  chk("R8 rom write ignored", d, 8'h77);
  endtask

  task automatic t_latch;
    logic [7:0] d;
    do_write(14'h3F05, 8'h5C);
    #1 chk("R9 latch on write", bus_latch, 8'h5C);
    do_read(14'h3F01, d);
    #1 chk("R9 latch on read", bus_latch, 8'h31);
    @(negedge clk); addr = 14'h3F05;
    @(negedge clk); #1 chk("R9 latch holds", bus_latch, 8'h31);
  endtask

  task automatic t_reset_keep;
    logic [7:0] d;
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    #1 chk("R9 latch cleared", bus_latch, 8'h00);
    do_read(14'h3F05, d); chk("R10 palette kept", d, 8'h5C);
    mirror_sel = 3'd2; do_read(14'h2000, d); chk("R10 nametable kept", d, 8'h10);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        #1 chk("R9 reset latch", bus_latch, 8'h00);
        rst_n = 1;
        t_seed;
        t_mode(3'd0, "R2 horizontal");
        t_mode(3'd1, "R3 vertical");
        t_mode(3'd2, "R4 page0");
        t_mode(3'd3, "R4 page1");
        t_mode(3'd4, "R5 four-screen");
        t_mode(3'd5, "R6 unused code 5");
        t_mode(3'd7, "R6 unused code 7");
        t_four_drop;
        t_palette;
        t_pattern;
        t_latch;
        t_reset_keep;
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule